// File: doc/BRIEF.md
# Reset Edge to Pulse Converter

This block turns each rising edge on a reset request into a reset pulse for one clock domain. The request can arrive at any time and need not be synchronous to the destination clock. The pulse goes high as soon as the edge arrives, without waiting for a clock. Downstream flops use it as an active-high asynchronous reset.

The pulse is released in step with the destination clock. A chain of synchronizer flops carries the release, so a metastable sample never reaches the output. A request that stays high after its edge is treated as one event, so the downstream logic is not held in reset for as long as the request is high. A short hold counter sets the number of clock cycles the pulse lasts after the edge has been seen in the clock domain.

The request edge is caught by a flop that the request itself clocks. That flop is cleared while the synchronized copy of it is high. An active-low power-on reset forces the whole block idle.

Top module: `rst_edge_pulse`

## Requirements
- R1: While rst_ni is low, rst_pulse_o is 0 and request edges are ignored. After rst_ni goes high, no pulse comes from an edge seen during reset, even if the request is still high.
- R2: A 0-to-1 transition on req_i drives rst_pulse_o high at once, with no clock edge needed.
- R3: rst_pulse_o falls only just after a rising edge of clk_i. Count the first rising edge after the request edge as edge 1. The pulse falls at edge 2*SYNC_STAGES+HOLD_CYCLES, which is edge 6 with the defaults.
- R4: Once high, rst_pulse_o stays high for at least one full clock cycle.
- R5: A request held high after its edge starts no second pulse.
- R6: A new request edge arriving between edge SYNC_STAGES and edge 2*SYNC_STAGES of a running pulse is absorbed, and the release edge does not change.
- R7: A new request edge arriving after that window while the pulse is still high extends the pulse. The output stays high without a gap and falls at edge 2*SYNC_STAGES+HOLD_CYCLES, counted from the new edge.
- R8: Taking rst_ni low during a pulse drives rst_pulse_o low at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Destination clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| req_i | input | 1 | Reset request; only its rising edge matters |
| rst_pulse_o | output | 1 | Active-high reset pulse: asserts asynchronously, releases synchronously |

## Verification
The embedded assertions check four things on every clock cycle:
- the edge flag stays clear while the synchronized copy is high,
- a rising pulse is still high one cycle later,
- the hold counter covers the fall of the synchronizer output,
- the counter never passes its load value.

Some behaviours only the directed scenarios can show, because they depend on when the request edge lands relative to the clock:
- the output rising before any clock edge,
- the exact cycle of release,
- a held request starting no second pulse,
- a second edge being absorbed or extending the pulse,
- the power-on reset cutting a pulse short.

// File: rtl/rep_pkg.sv
`timescale 1ns/1ps
package rep_pkg;
  // clock edges from request edge to release, edge 1 being the first after the request
  function automatic int unsigned release_edge(int unsigned stages, int unsigned hold);
    return 2 * stages + hold;
  endfunction
endpackage

// File: rtl/rep_edge_catch.sv
`timescale 1ns/1ps
module rep_edge_catch (
  input  logic req_i,
  input  logic clr_i,
  output logic flag_o
);
  // clocked by the request itself, D tied high
  always_ff @(posedge req_i or posedge clr_i) begin
    if (clr_i) flag_o <= 1'b0;
    else       flag_o <= 1'b1;
  end
endmodule

// File: rtl/rep_sync.sv
`timescale 1ns/1ps
module rep_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stg_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stg_q[0] <= 1'b0;
          else         stg_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stg_q[g] <= 1'b0;
          else         stg_q[g] <= stg_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/rep_hold.sv
`timescale 1ns/1ps
module rep_hold #(
  parameter int unsigned HOLD = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic busy_o
);
  localparam int unsigned CW = (HOLD < 2) ? 1 : $clog2(HOLD + 1);
  localparam logic [CW-1:0] LOAD_V = CW'(HOLD);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= LOAD_V;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  // R3: counter never exceeds its load value
  a_r3_hold_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LOAD_V);
endmodule

// File: rtl/rst_edge_pulse.sv
`timescale 1ns/1ps
module rst_edge_pulse #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned HOLD_CYCLES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic rst_pulse_o
);
  import rep_pkg::*;

  localparam int unsigned REL_EDGE = release_edge(SYNC_STAGES, HOLD_CYCLES);

  logic edge_flag;
  logic rel_q;
  logic hold_busy;
  logic flag_clr;

  // flag held clear while its synchronized copy is high
  assign flag_clr = ~rst_ni | rel_q;

  rep_edge_catch u_catch (
    .req_i  (req_i),
    .clr_i  (flag_clr),
    .flag_o (edge_flag)
  );

  rep_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (edge_flag),
    .q_o    (rel_q)
  );

  rep_hold #(.HOLD(HOLD_CYCLES)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (rel_q),
    .busy_o (hold_busy)
  );

  // flag covers assertion, rel_q and counter cover synchronous release
  assign rst_pulse_o = edge_flag | rel_q | hold_busy;

  initial begin
    if (SYNC_STAGES < 2 || HOLD_CYCLES < 1 || REL_EDGE < 5)
      $error("rst_edge_pulse: SYNC_STAGES >= 2 and HOLD_CYCLES >= 1 required");
  end

  // R6: edges are absorbed while the release copy is high
  a_r6_flag_clear_in_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_q |-> !edge_flag);

  // R4: pulse lasts at least one full cycle
  a_r4_min_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_pulse_o) |=> rst_pulse_o);

  // R3: hold counter takes over when the synchronizer output falls
  a_r3_release_covered: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rel_q) |-> hold_busy);
endmodule

// File: tb/sim_rst_edge_pulse.sv
`timescale 1ns/1ps
module sim_rst_edge_pulse;
  localparam int REL = 6; // 2*2+2 with default parameters

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req = 1'b0;
  logic pulse;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  rst_edge_pulse u0 (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .req_i       (req),
    .rst_pulse_o (pulse)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  // raise request mid low phase; next posedge is edge 1
  task automatic raise_req();
    @(negedge clk); #0.5;
    req = 1'b1;
    #0.2;
  endtask

  task automatic idle_gap();
    @(negedge clk); req = 1'b0;
    edges(10);
    check("R3 idle between tests", pulse, 1'b0);
  endtask

  task automatic t_por();
    rst_ni = 1'b0;
    edges(2);
    check("R1 output low in reset", pulse, 1'b0);
    raise_req();
    check("R1 edge ignored in reset", pulse, 1'b0);
    edges(3);
    @(negedge clk); rst_ni = 1'b1;
    edges(10);
    check("R1 no pulse after reset release", pulse, 1'b0);
    idle_gap();
  endtask

  task automatic t_basic();
    raise_req();
    check("R2 asserts before any clock", pulse, 1'b1);
    for (int k = 1; k <= REL + 2; k++) begin
      @(posedge clk); #1;
      check(k < REL ? "R4 pulse held" : "R3 released at edge 6", pulse, k < REL);
      if (k == REL - 1) begin
        #3;
        check("R3 still high just before release edge", pulse, 1'b1);
      end
    end
  endtask

  task automatic t_held();
    // request still high from t_basic
    edges(20);
    check("R5 held request gives no second pulse", pulse, 1'b0);
    idle_gap();
  endtask

  task automatic t_absorb();
    raise_req();
    check("R6 first edge asserts", pulse, 1'b1);
    @(posedge clk); @(negedge clk); req = 1'b0;
    @(posedge clk); @(negedge clk); #0.5; req = 1'b1; // after edge 2
    for (int k = 3; k <= REL + 1; k++) begin
      @(posedge clk); #1;
      check("R6 absorbed edge keeps release edge", pulse, k < REL);
    end
    edges(10);
    check("R6 no late pulse from absorbed edge", pulse, 1'b0);
    idle_gap();
  endtask

  task automatic t_extend();
    raise_req();
    @(posedge clk); @(negedge clk); req = 1'b0;
    for (int k = 2; k <= 5; k++) begin
      @(posedge clk); #1;
      check("R7 first pulse high", pulse, 1'b1);
    end
    @(negedge clk); #0.5; req = 1'b1; // after edge 5
    for (int k = 6; k <= 5 + REL + 1; k++) begin
      @(posedge clk); #1;
      check("R7 extended pulse", pulse, k < 5 + REL);
    end
    idle_gap();
  endtask

  task automatic t_por_mid();
    raise_req();
    edges(2);
    check("R8 pulse running", pulse, 1'b1);
    @(negedge clk); #0.5; rst_ni = 1'b0; #0.2;
    check("R8 reset cuts pulse at once", pulse, 1'b0);
    edges(2);
    @(negedge clk); rst_ni = 1'b1;
    edges(10);
    check("R8 no pulse after reset with request high", pulse, 1'b0);
    idle_gap();
  endtask

  initial begin
    #50000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_por();
    t_basic();
    t_held();
    t_absorb();
    t_extend();
    t_por_mid();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule